// File: doc/BRIEF.md
# Vectored Interrupt Mask and Priority Unit

This block sits beside a small processor core and decides which interrupt the core should service next. It watches five request sources. The first is a non-maskable line. Three restart lines (high, middle and low) have fixed priority. The last is a general request. It filters the restart lines and the general request through a software-written mask and a global enable flag. It then presents the winning source as a one-hot code together with a fixed 16-bit vector address. The core answers with a one-cycle acknowledge. That acknowledge retires the accepted source and turns the global enable off.

Software controls the block through two byte-wide ports. A control byte written through the mask-write port updates the per-line masks, can drop a pending high-line edge, and can set or clear a single serial output bit. The mask update happens only when the enabling bit is set. A status-read strobe captures a byte holding the masks, the enable flag and the pending state of each restart source and the non-maskable line. The block does not fetch instructions and does not run the acknowledge bus cycle for the general request. It only says which vector to take and when.

Top module: `irqv_unit`

## Requirements
- R1: After reset `take_o` is 0, `vector_o` is 0x0000, `sod_o` is 0, all three line masks are set (blocked) and the global enable is 0.
- R2: Priority from highest to lowest is: non-maskable, high line, middle line, low line, general request. The vectors are 0x0024, 0x003C, 0x0034 and 0x002C, and 0x0000 for the general request. The `src_o` bits are 4 = non-maskable, 3 = high, 2 = middle, 1 = low and 0 = general.
- R3: The non-maskable line is latched on a rising edge. It is taken regardless of masks and the global enable.
- R4: The high line is latched on a rising edge and is not sensed by level. A line held high after its latch is retired does not request again. The latch is kept while the line is masked.
- R5: The middle and low lines are level-sensed. Each is taken only while its mask bit is 0 and the global enable is 1.
- R6: A control-byte write loads bits 2:0 into the masks only when bit 3 is 1 and bit 5 is 0. Bit 0 masks the low line, bit 1 the middle line and bit 2 the high line, and 1 blocks the line. Bit 5 set makes the whole write have no effect.
- R7: A control-byte write with bit 4 set clears the high-line edge latch.
- R8: A control-byte write with bit 6 set loads bit 7 into `sod_o`. With bit 6 clear, `sod_o` keeps its value.
- R9: A pulse on `ei_i` sets the global enable and a pulse on `di_i` clears it. The general request is taken only while the enable is 1.
- R10: In the cycle after `srd_i`, `sdata_o` holds the following: bits 2:0 are the masks, bit 3 the enable, bit 4 the low-line level, bit 5 the middle-line level, bit 6 the high-line latch and bit 7 the non-maskable latch.
- R11: An `ack_i` while `take_o` is 1 has three effects. It clears the global enable, clears the latch of the accepted edge source, and drops `take_o` in the next cycle.
- R12: A level request shows on `take_o` one clock after it is sampled. An edge request shows two clocks after its rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable request, edge-latched |
| irq_hi_i | input | 1 | High-priority restart line, edge-latched |
| irq_mid_i | input | 1 | Middle restart line, level |
| irq_lo_i | input | 1 | Low restart line, level |
| intr_i | input | 1 | General request, level |
| ei_i | input | 1 | Set global enable |
| di_i | input | 1 | Clear global enable |
| mwr_i | input | 1 | Control-byte write strobe |
| mdata_i | input | 8 | Control byte |
| srd_i | input | 1 | Status read strobe |
| ack_i | input | 1 | Core accepts the offered interrupt |
| sdata_o | output | 8 | Captured status byte |
| sod_o | output | 1 | Serial data output bit |
| take_o | output | 1 | An interrupt is offered |
| vector_o | output | 16 | Vector address of the offered source |
| src_o | output | 5 | One-hot offered source |

## Verification
The checker watches several rules on every cycle:
- the vector is zero after reset;
- an acknowledge drops the offer and the enable;
- a pending non-maskable edge wins the next cycle;
- the low line is never offered unless it was unmasked and enabled;
- the masks and the serial bit stay put unless an enabled write touches them.

Only the bench's scenarios can show some other behaviours:
- the full priority order across mixed request patterns;
- that a held high line does not come back after acknowledge;
- that a masked edge survives until unmasked;
- the status byte layout;
- the exact latency of level and edge requests.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int VEC_W  = 16;
    localparam int NSRC   = 5;
    localparam int NMASK  = 3;
    localparam int SIDX_W = $clog2(NSRC);

    localparam int SRC_GEN = 0;
    localparam int SRC_LO  = 1;
    localparam int SRC_MID = 2;
    localparam int SRC_HI  = 3;
    localparam int SRC_NMI = 4;

    function automatic logic [VEC_W-1:0] vec_of(input logic [SIDX_W-1:0] idx);
        case (idx)
            SIDX_W'(SRC_NMI): vec_of = VEC_W'(16'h0024);
            SIDX_W'(SRC_HI):  vec_of = VEC_W'(16'h003C);
            SIDX_W'(SRC_MID): vec_of = VEC_W'(16'h0034);
            SIDX_W'(SRC_LO):  vec_of = VEC_W'(16'h002C);
            default:          vec_of = '0;
        endcase
    endfunction

    typedef struct packed {
        logic [NMASK-1:0] mask;
        logic             ie;
        logic             sod;
        logic             take;
        logic [VEC_W-1:0] vec;
        logic [NSRC-1:0]  src;
        logic [7:0]       stat;
    } ctl_t;
endpackage

// File: rtl/irqv_edge.sv
module irqv_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic clr_i,
    output logic pend_o
);
    typedef struct packed {
        logic prev;
        logic lat;
    } edge_t;

    edge_t d, q;

    always_comb begin
        d.prev = lvl_i;
        d.lat  = (lvl_i & ~q.prev) | (q.lat & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend_o = q.lat;
endmodule

// File: rtl/irqv_prio.sv
module irqv_prio #(
    parameter int N = 5
) (
    input  logic [N-1:0]         req_i,
    output logic [N-1:0]         gnt_o,
    output logic [$clog2(N)-1:0] idx_o,
    output logic                 valid_o
);
    always_comb begin
        gnt_o   = '0;
        idx_o   = '0;
        valid_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i] && !valid_o) begin
                gnt_o[i] = 1'b1;
                idx_o    = ($clog2(N))'(i);
                valid_o  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irqv_unit.sv
module irqv_unit
    import irqv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_i,
    input  logic             irq_hi_i,
    input  logic             irq_mid_i,
    input  logic             irq_lo_i,
    input  logic             intr_i,
    input  logic             ei_i,
    input  logic             di_i,
    input  logic             mwr_i,
    input  logic [7:0]       mdata_i,
    input  logic             srd_i,
    input  logic             ack_i,
    output logic [7:0]       sdata_o,
    output logic             sod_o,
    output logic             take_o,
    output logic [VEC_W-1:0] vector_o,
    output logic [NSRC-1:0]  src_o
);
    localparam int NEDGE = 2;

    ctl_t d, q;

    logic              wr_ok;
    logic              accept;
    logic [NEDGE-1:0]  edge_lvl;
    logic [NEDGE-1:0]  edge_clr;
    logic [NEDGE-1:0]  edge_pend;
    logic              nmi_pend;
    logic              hi_pend;
    logic [NSRC-1:0]   req;
    logic [NSRC-1:0]   gnt;
    logic [SIDX_W-1:0] win;
    logic              win_valid;
    logic              ie_now;
    logic [NMASK-1:0]  mask_now;

    assign wr_ok  = mwr_i & ~mdata_i[5];
    assign accept = ack_i & q.take;

    // edge source 0 = non-maskable, 1 = high restart line
    assign edge_lvl = {irq_hi_i, nmi_i};
    assign edge_clr = {(wr_ok & mdata_i[4]) | (accept & q.src[SRC_HI]),
                       accept & q.src[SRC_NMI]};

    generate
        for (genvar k = 0; k < NEDGE; k++) begin : g_edge
            irqv_edge u_edge (
                .clk    (clk),
                .rst_n  (rst_n),
                .lvl_i  (edge_lvl[k]),
                .clr_i  (edge_clr[k]),
                .pend_o (edge_pend[k])
            );
        end
    endgenerate

    assign nmi_pend = edge_pend[0];
    assign hi_pend  = edge_pend[1];

    always_comb begin
        req          = '0;
        req[SRC_NMI] = nmi_pend;
        req[SRC_HI]  = hi_pend   & ~q.mask[2] & q.ie;
        req[SRC_MID] = irq_mid_i & ~q.mask[1] & q.ie;
        req[SRC_LO]  = irq_lo_i  & ~q.mask[0] & q.ie;
        req[SRC_GEN] = intr_i    & q.ie;
    end

    irqv_prio #(.N(NSRC)) u_prio (
        .req_i   (req),
        .gnt_o   (gnt),
        .idx_o   (win),
        .valid_o (win_valid)
    );

    always_comb begin
        d = q;
        if (wr_ok && mdata_i[3]) d.mask = mdata_i[NMASK-1:0];
        if (wr_ok && mdata_i[6]) d.sod  = mdata_i[7];
        if (ei_i)   d.ie = 1'b1;
        if (di_i)   d.ie = 1'b0;
        if (accept) d.ie = 1'b0;
        d.take = win_valid & ~accept;
        if (d.take) begin
            d.vec = vec_of(win);
            d.src = gnt;
        end else begin
            d.src = '0;
        end
        if (srd_i) d.stat = {nmi_pend, hi_pend, irq_mid_i, irq_lo_i, q.ie, q.mask};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.mask <= '1;
        end else begin
            q <= d;
        end
    end

    assign ie_now   = q.ie;
    assign mask_now = q.mask;

    assign sdata_o  = q.stat;
    assign sod_o    = q.sod;
    assign take_o   = q.take;
    assign vector_o = q.vec;
    assign src_o    = q.src;
endmodule

// File: rtl/irqv_unit_chk.sv
module irqv_unit_chk
    import irqv_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ack_i,
    input logic             mwr_i,
    input logic [7:0]       mdata_i,
    input logic             take_o,
    input logic [NSRC-1:0]  src_o,
    input logic [VEC_W-1:0] vector_o,
    input logic             sod_o,
    input logic             ie_q,
    input logic [NMASK-1:0] mask_q,
    input logic             nmi_pend
);
    AST_RESET_VEC_ZERO: assert property (@(posedge clk)
        !rst_n |=> vector_o == '0); // R1

    AST_ACK_DROPS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i && take_o |=> !take_o); // R11

    AST_ACK_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i && take_o |=> !ie_q); // R11

    AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pend && !ack_i |=> take_o && src_o[SRC_NMI] && vector_o == VEC_W'(16'h0024)); // R3

    AST_LO_NEEDS_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
        take_o && src_o[SRC_LO] |-> $past(!mask_q[0] && ie_q)); // R5

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(mwr_i && mdata_i[3] && !mdata_i[5]) |=> $stable(mask_q)); // R6

    AST_SOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(mwr_i && mdata_i[6] && !mdata_i[5]) |=> $stable(sod_o)); // R8
endmodule

bind irqv_unit irqv_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_i    (ack_i),
    .mwr_i    (mwr_i),
    .mdata_i  (mdata_i),
    .take_o   (take_o),
    .src_o    (src_o),
    .vector_o (vector_o),
    .sod_o    (sod_o),
    .ie_q     (ie_now),
    .mask_q   (mask_now),
    .nmi_pend (nmi_pend)
);

// File: tb/irqv_unit_test.sv
module irqv_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_i = 0, irq_hi_i = 0, irq_mid_i = 0, irq_lo_i = 0, intr_i = 0;
    logic        ei_i = 0, di_i = 0, mwr_i = 0, srd_i = 0, ack_i = 0;
    logic [7:0]  mdata_i = '0;
    logic [7:0]  sdata_o;
    logic        sod_o, take_o;
    logic [15:0] vector_o;
    logic [4:0]  src_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqv_unit uut (
        .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .irq_hi_i(irq_hi_i),
        .irq_mid_i(irq_mid_i), .irq_lo_i(irq_lo_i), .intr_i(intr_i),
        .ei_i(ei_i), .di_i(di_i), .mwr_i(mwr_i), .mdata_i(mdata_i),
        .srd_i(srd_i), .ack_i(ack_i), .sdata_o(sdata_o), .sod_o(sod_o),
        .take_o(take_o), .vector_o(vector_o), .src_o(src_o)
    );

    typedef struct packed {
        logic [2:0]  mask;
        logic        ie;
        logic        nmi;
        logic        hi;
        logic        mid;
        logic        lo;
        logic        gen;
        logic        take;
        logic [15:0] vec;
    } vec_t;

    // R2 R3 R5 R9: priority and gating patterns
    localparam vec_t TBL [NVEC] = '{
        '{3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000},
        '{3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h002C},
        '{3'b000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0034},
        '{3'b000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'h003C},
        '{3'b000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0024},
        '{3'b111, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0000},
        '{3'b111, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0024},
        '{3'b100, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0034},
        '{3'b000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000},
        '{3'b010, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'h002C}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] v);
        mwr_i = 1; mdata_i = v;
        tick();
        mwr_i = 0; mdata_i = '0;
    endtask

    task automatic rd();
        srd_i = 1;
        tick();
        srd_i = 0;
    endtask

    task automatic pulse_ack();
        ack_i = 1;
        tick();
        ack_i = 0;
    endtask

    task automatic set_ie(logic v);
        ei_i = v; di_i = ~v;
        tick();
        ei_i = 0; di_i = 0;
    endtask

    task automatic drop_all();
        nmi_i = 0; irq_hi_i = 0; irq_mid_i = 0; irq_lo_i = 0; intr_i = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 take", take_o, 0);
        chk("R1 vector", vector_o, 16'h0000);
        chk("R1 sod", sod_o, 0);
        rst_n = 1;
        tick();
        rd();
        chk("R1 R10 status after reset", sdata_o, 8'h07);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            mwr_i = 1; mdata_i = {5'b00001, TBL[i].mask};
            ei_i = TBL[i].ie; di_i = ~TBL[i].ie;
            tick();
            mwr_i = 0; mdata_i = '0; ei_i = 0; di_i = 0;
            nmi_i = TBL[i].nmi; irq_hi_i = TBL[i].hi; irq_mid_i = TBL[i].mid;
            irq_lo_i = TBL[i].lo; intr_i = TBL[i].gen;
            repeat (3) tick();
            chk($sformatf("R2 take row %0d", i), take_o, TBL[i].take);
            if (TBL[i].take) begin
                chk($sformatf("R2 vector row %0d", i), vector_o, TBL[i].vec);
                pulse_ack();
                chk($sformatf("R11 take after ack row %0d", i), take_o, 0);
            end
            drop_all();
            di_i = 1; mwr_i = 1; mdata_i = 8'h10;
            tick();
            di_i = 0; mwr_i = 0; mdata_i = '0;
            tick();
            chk($sformatf("R11 idle after cleanup row %0d", i), take_o, 0);
        end

        // R6: mask load rules
        wr(8'h0F);
        wr(8'h00);
        rd();
        chk("R6 no load without bit3", sdata_o, 8'h07);
        wr(8'h28);
        rd();
        chk("R6 bit5 ignores write", sdata_o, 8'h07);
        wr(8'h0D);
        rd();
        chk("R6 load masks", sdata_o, 8'h05);

        // R8: serial output
        wr(8'hC0);
        chk("R8 sod set", sod_o, 1);
        wr(8'h80);
        chk("R8 sod held without bit6", sod_o, 1);
        wr(8'h40);
        chk("R8 sod cleared", sod_o, 0);

        // R4: masked edge kept, no level re-trigger
        wr(8'h0F);
        set_ie(1);
        irq_hi_i = 1;
        tick();
        rd();
        chk("R4 R10 masked latch visible", sdata_o, 8'h4F);
        chk("R4 masked not taken", take_o, 0);
        wr(8'h08);
        tick();
        chk("R4 taken when unmasked", take_o, 1);
        chk("R4 vector", vector_o, 16'h003C);
        pulse_ack();
        rd();
        chk("R11 ie and latch cleared", sdata_o, 8'h00);
        set_ie(1);
        repeat (3) tick();
        chk("R4 held level no retrigger", take_o, 0);
        rd();
        chk("R4 latch still clear", sdata_o, 8'h08);

        // R7: latch cleared by control write
        irq_hi_i = 0;
        set_ie(0);
        irq_hi_i = 1;
        tick();
        rd();
        chk("R7 latch set", sdata_o, 8'h40);
        wr(8'h10);
        rd();
        chk("R7 latch cleared by bit4", sdata_o, 8'h00);
        irq_hi_i = 0;

        // R9 R12: latency and enable
        set_ie(1);
        intr_i = 1;
        tick();
        chk("R9 R12 general taken", take_o, 1);
        intr_i = 0;
        set_ie(0);
        tick();
        irq_lo_i = 1;
        tick();
        chk("R9 disabled not taken", take_o, 0);
        set_ie(1);
        tick();
        chk("R12 level one clock", take_o, 1);
        chk("R12 level vector", vector_o, 16'h002C);
        irq_lo_i = 0;
        set_ie(0);
        tick();
        nmi_i = 1;
        tick();
        chk("R3 R12 edge not yet", take_o, 0);
        tick();
        chk("R3 R12 edge two clocks", take_o, 1);
        chk("R3 nmi src", src_o, 5'b10000);
        pulse_ack();
        tick();
        chk("R3 R11 nmi retired", take_o, 0);
        nmi_i = 0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule